// File: doc/BRIEF.md
# Redundant Manchester Command Receiver

This block is the receive side of a remote module on a command/response serial bus. The module listens on two redundant lines. Each line is sampled at eight samples per bit, and the block hunts on both lines at once for a sync pattern: one and a half bit times high, then one and a half bit times low. After the sync it decodes 32 Manchester-coded data bits and one odd parity bit.

When a word arrives intact, the block splits it into fields. It accepts the word if the embedded module address equals the strapped address, or if the word is a broadcast. It then presents the device number, command type and payload, together with a one-cycle valid strobe. A response request goes with every accepted command except a broadcast. Coding faults set three sticky flags that stay set until reset: bad sync timing, a missing mid-bit transition and bad parity.

If both lines carry a word, only one of them is used. The line whose sync finished first wins, and bus A wins a tie. If the winning word turns out to be corrupt, the block takes the word still arriving on the other line.

Top module: `mcr_terminal`

## Requirements
- R1: While reset is asserted and right after it, every output is 0.
- R2: A frame is a sync followed by 33 bits, each 8 samples long, sent most significant bit first, with the parity bit last. The sync is 12 samples high then 12 samples low. A 1 bit is sent high for the first half and low for the second half; a 0 bit is the reverse. In the 32-bit word, bits [31:26] hold the module address, [25:21] the device, [20:17] the command type and [16:0] the payload. For each accepted word, `cmd_valid_o` pulses for exactly one cycle and the field outputs show that word.
- R3: A word whose address equals `my_addr_i` is accepted, and `resp_req_o` pulses in the same cycle as `cmd_valid_o`. A word with any other address, other than a broadcast, gives neither strobe.
- R4: A word with address 63 and command type 15 is a broadcast. It is accepted whatever the strap, with `cmd_bcast_o`=1 and no `resp_req_o`. A word with address 63 and any other type is handled as an ordinary address.
- R5: The parity bit makes the number of 1s over the 32 data bits plus the parity bit odd. A word that breaks this rule is discarded, and it sets `err_parity_o`, which stays set until reset.
- R6: If the two half-bit samples of any bit are equal, the word is aborted, and `err_manch_o` is set and stays set until reset.
- R7: A sync high run of 10 to 13 samples is accepted. A run of 9 or fewer samples, or of 14 or more, sets `err_sync_o`, which stays set until reset, and gives no command.
- R8: A valid word is accepted from either line. `cmd_bus_o` is 0 for bus A and 1 for bus B.
- R9: When both lines carry a word, only the word whose sync completed first is accepted. Bus A wins when both syncs complete in the same cycle.
- R10: If the word that won the arbitration fails its parity or coding check, the word still arriving on the other line is accepted in its place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 8 samples per bit |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_a_i | input | 1 | Line A, idle low |
| bus_b_i | input | 1 | Line B, idle low |
| my_addr_i | input | 6 | Strapped module address |
| cmd_valid_o | output | 1 | One-cycle strobe for an accepted command |
| resp_req_o | output | 1 | One-cycle strobe asking for a response |
| cmd_bcast_o | output | 1 | The last accepted command was a broadcast |
| cmd_bus_o | output | 1 | Line that delivered the last accepted command |
| cmd_dev_o | output | 5 | Device number |
| cmd_type_o | output | 4 | Command type |
| cmd_data_o | output | 17 | Command payload |
| err_parity_o | output | 1 | Sticky parity error |
| err_manch_o | output | 1 | Sticky Manchester coding error |
| err_sync_o | output | 1 | Sticky sync timing error |

## Verification
Single clean frames are sent on each line alone, with payloads of all zeros and all ones. These separate the field slicing and the reporting of which line delivered the word. Matching, non-matching, broadcast and address-63 non-broadcast words tell the address and broadcast decisions apart.

Frames with a flipped parity bit, a bit with no mid-bit transition, and sync high runs of 8, 11, 13, 14 and 16 samples bound each error path and the sync tolerance window. Paired frames are also sent on both lines, with bus B ahead by a few samples, with both syncs aligned, and with a corrupt leader. These separate first-come arbitration, the tie rule and failover to the other line.

// File: rtl/mcr_pkg.sv
package mcr_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 6;
  localparam int DEV_W  = 5;
  localparam int TYPE_W = 4;
  localparam int DATA_W = 17;
  localparam int NBUS   = 2;
  localparam int BUS_W  = (NBUS > 1) ? $clog2(NBUS) : 1;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DEV_W-1:0]  dev;
    logic [TYPE_W-1:0] ctype;
    logic [DATA_W-1:0] data;
  } cmd_t;

  typedef enum logic [1:0] {RX_IDLE, RX_SYNC_HI, RX_SYNC_LO, RX_DATA} rx_state_e;

  // odd parity over data plus parity bit
  function automatic logic parity_ok(logic [WORD_W-1:0] w, logic p);
    return ^{w, p};
  endfunction

  function automatic cmd_t split_word(logic [WORD_W-1:0] w);
    return cmd_t'(w);
  endfunction

  function automatic logic is_broadcast(cmd_t c, logic [TYPE_W-1:0] btype);
    return (c.addr == '1) && (c.ctype == btype);
  endfunction
endpackage

// File: rtl/mcr_line_rx.sv
module mcr_line_rx
  import mcr_pkg::*;
#(
  parameter int OVS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_i,
  output logic              sync_done_o,
  output logic              word_done_o,
  output logic              word_fail_o,
  output logic [WORD_W-1:0] word_o,
  output logic              err_sync_o,
  output logic              err_manch_o,
  output logic              err_par_o
);
  localparam int SYNC_N  = (3 * OVS) / 2;
  localparam int TOL     = OVS / 4;
  localparam int SHI_MIN = SYNC_N - TOL;
  localparam int SHI_MAX = SYNC_N + TOL;
  localparam int SLO_MIN = SYNC_N - TOL;
  localparam int Q1      = OVS / 4;
  localparam int Q3      = (3 * OVS) / 4;
  localparam int BIT_N   = WORD_W + 1;
  localparam int CNT_W   = $clog2(SHI_MAX + 1);
  localparam int PH_W    = $clog2(OVS);
  localparam int BC_W    = $clog2(BIT_N + 1);

  rx_state_e         state;
  logic              smp, smp_q;
  logic [CNT_W-1:0]  cnt;
  logic [PH_W-1:0]   phase;
  logic [BC_W-1:0]   bitcnt;
  logic              half_v;
  logic [WORD_W:0]   shreg;
  logic [WORD_W:0]   next_vec;

  assign next_vec = {shreg[WORD_W-1:0], half_v};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= RX_IDLE;
      smp         <= 1'b0;
      smp_q       <= 1'b0;
      cnt         <= '0;
      phase       <= '0;
      bitcnt      <= '0;
      half_v      <= 1'b0;
      shreg       <= '0;
      word_o      <= '0;
      sync_done_o <= 1'b0;
      word_done_o <= 1'b0;
      word_fail_o <= 1'b0;
      err_sync_o  <= 1'b0;
      err_manch_o <= 1'b0;
      err_par_o   <= 1'b0;
    end else begin
      smp         <= line_i;
      smp_q       <= smp;
      sync_done_o <= 1'b0;
      word_done_o <= 1'b0;
      word_fail_o <= 1'b0;
      err_sync_o  <= 1'b0;
      err_manch_o <= 1'b0;
      err_par_o   <= 1'b0;
      case (state)
        RX_IDLE: begin
          if (smp && !smp_q) begin
            state <= RX_SYNC_HI;
            cnt   <= CNT_W'(1);
          end
        end
        RX_SYNC_HI: begin
          if (smp) begin
            if (cnt == CNT_W'(SHI_MAX - 1)) begin
              err_sync_o <= 1'b1;
              state      <= RX_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else if (cnt >= CNT_W'(SHI_MIN)) begin
            state <= RX_SYNC_LO;
            cnt   <= CNT_W'(1);
          end else begin
            err_sync_o <= 1'b1;
            state      <= RX_IDLE;
          end
        end
        RX_SYNC_LO: begin
          if (!smp) begin
            if (cnt == CNT_W'(SYNC_N - 1)) begin
              state       <= RX_DATA;
              phase       <= '0;
              bitcnt      <= '0;
              sync_done_o <= 1'b1;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else if (cnt >= CNT_W'(SLO_MIN)) begin
            // data started a little early: this sample is phase 0
            state       <= RX_DATA;
            phase       <= PH_W'(1);
            bitcnt      <= '0;
            sync_done_o <= 1'b1;
          end else begin
            err_sync_o <= 1'b1;
            state      <= RX_IDLE;
          end
        end
        RX_DATA: begin
          phase <= (phase == PH_W'(OVS - 1)) ? '0 : phase + 1'b1;
          if (phase == PH_W'(Q1)) half_v <= smp;
          if (phase == PH_W'(Q3)) begin
            if (smp == half_v) begin
              err_manch_o <= 1'b1;
              word_fail_o <= 1'b1;
              state       <= RX_IDLE;
            end else begin
              shreg  <= next_vec;
              bitcnt <= bitcnt + 1'b1;
              if (bitcnt == BC_W'(BIT_N - 1)) begin
                state <= RX_IDLE;
                if (parity_ok(next_vec[WORD_W:1], next_vec[0])) begin
                  word_done_o <= 1'b1;
                  word_o      <= next_vec[WORD_W:1];
                end else begin
                  err_par_o   <= 1'b1;
                  word_fail_o <= 1'b1;
                end
              end
            end
          end
        end
        default: state <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mcr_cmd_select.sv
module mcr_cmd_select
  import mcr_pkg::*;
#(
  parameter logic [TYPE_W-1:0] BCAST_TYPE = 4'hF
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NBUS-1:0]            sync_i,
  input  logic [NBUS-1:0]            done_i,
  input  logic [NBUS-1:0]            fail_i,
  input  logic [NBUS-1:0][WORD_W-1:0] word_i,
  input  logic [ADDR_W-1:0]          my_addr_i,
  output logic [NBUS-1:0]            acc_o,
  output logic                       cmd_valid_o,
  output logic                       resp_req_o,
  output logic                       cmd_bcast_o,
  output logic [BUS_W-1:0]           cmd_bus_o,
  output logic [DEV_W-1:0]           cmd_dev_o,
  output logic [TYPE_W-1:0]          cmd_type_o,
  output logic [DATA_W-1:0]          cmd_data_o
);
  logic [NBUS-1:0]   own, shadow, own_n, sh_n;
  logic              promote;
  logic [WORD_W-1:0] sel_word;
  logic [BUS_W-1:0]  sel_idx;
  cmd_t              fields;
  logic              bcast_hit, addr_hit;

  assign acc_o = done_i & own;

  always_comb begin
    own_n   = own;
    sh_n    = shadow;
    promote = 1'b0;
    for (int i = 0; i < NBUS; i++) begin
      if (done_i[i] || fail_i[i]) begin
        if (own[i]) begin
          own_n[i] = 1'b0;
          if (fail_i[i]) promote = 1'b1;
        end
        sh_n[i] = 1'b0;
      end
    end
    if (promote) begin
      for (int j = 0; j < NBUS; j++) begin
        if (sh_n[j] && (own_n == '0)) begin
          own_n[j] = 1'b1;
          sh_n[j]  = 1'b0;
        end
      end
    end
    for (int i = 0; i < NBUS; i++) begin
      if (sync_i[i]) begin
        if (own_n == '0) own_n[i] = 1'b1;
        else             sh_n[i]  = 1'b1;
      end
    end
  end

  always_comb begin
    sel_word = '0;
    sel_idx  = '0;
    for (int i = 0; i < NBUS; i++) begin
      if (acc_o[i]) begin
        sel_word = word_i[i];
        sel_idx  = BUS_W'(i);
      end
    end
  end

  assign fields    = split_word(sel_word);
  assign bcast_hit = is_broadcast(fields, BCAST_TYPE);
  assign addr_hit  = (fields.addr == my_addr_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      own         <= '0;
      shadow      <= '0;
      cmd_valid_o <= 1'b0;
      resp_req_o  <= 1'b0;
      cmd_bcast_o <= 1'b0;
      cmd_bus_o   <= '0;
      cmd_dev_o   <= '0;
      cmd_type_o  <= '0;
      cmd_data_o  <= '0;
    end else begin
      own         <= own_n;
      shadow      <= sh_n;
      cmd_valid_o <= 1'b0;
      resp_req_o  <= 1'b0;
      if ((|acc_o) && (bcast_hit || addr_hit)) begin
        cmd_valid_o <= 1'b1;
        resp_req_o  <= !bcast_hit;
        cmd_bcast_o <= bcast_hit;
        cmd_bus_o   <= sel_idx;
        cmd_dev_o   <= fields.dev;
        cmd_type_o  <= fields.ctype;
        cmd_data_o  <= fields.data;
      end
    end
  end
endmodule

// File: rtl/mcr_terminal.sv
module mcr_terminal
  import mcr_pkg::*;
#(
  parameter int                OVS        = 8,
  parameter logic [TYPE_W-1:0] BCAST_TYPE = 4'hF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_a_i,
  input  logic              bus_b_i,
  input  logic [ADDR_W-1:0] my_addr_i,
  output logic              cmd_valid_o,
  output logic              resp_req_o,
  output logic              cmd_bcast_o,
  output logic              cmd_bus_o,
  output logic [DEV_W-1:0]  cmd_dev_o,
  output logic [TYPE_W-1:0] cmd_type_o,
  output logic [DATA_W-1:0] cmd_data_o,
  output logic              err_parity_o,
  output logic              err_manch_o,
  output logic              err_sync_o
);
  logic [NBUS-1:0]             line_w;
  logic [NBUS-1:0]             sync_w, done_w, fail_w, acc_w;
  logic [NBUS-1:0]             esync_w, emanch_w, epar_w;
  logic [NBUS-1:0][WORD_W-1:0] word_w;

  assign line_w = {bus_b_i, bus_a_i};

  for (genvar g = 0; g < NBUS; g++) begin : g_rx
    mcr_line_rx #(.OVS(OVS)) i_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .line_i      (line_w[g]),
      .sync_done_o (sync_w[g]),
      .word_done_o (done_w[g]),
      .word_fail_o (fail_w[g]),
      .word_o      (word_w[g]),
      .err_sync_o  (esync_w[g]),
      .err_manch_o (emanch_w[g]),
      .err_par_o   (epar_w[g])
    );
  end

  mcr_cmd_select #(.BCAST_TYPE(BCAST_TYPE)) i_sel (
    .clk         (clk),
    .rst_n       (rst_n),
    .sync_i      (sync_w),
    .done_i      (done_w),
    .fail_i      (fail_w),
    .word_i      (word_w),
    .my_addr_i   (my_addr_i),
    .acc_o       (acc_w),
    .cmd_valid_o (cmd_valid_o),
    .resp_req_o  (resp_req_o),
    .cmd_bcast_o (cmd_bcast_o),
    .cmd_bus_o   (cmd_bus_o),
    .cmd_dev_o   (cmd_dev_o),
    .cmd_type_o  (cmd_type_o),
    .cmd_data_o  (cmd_data_o)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_parity_o <= 1'b0;
      err_manch_o  <= 1'b0;
      err_sync_o   <= 1'b0;
    end else begin
      err_parity_o <= err_parity_o | (|epar_w);
      err_manch_o  <= err_manch_o  | (|emanch_w);
      err_sync_o   <= err_sync_o   | (|esync_w);
    end
  end
endmodule

// File: rtl/mcr_terminal_chk.sv
module mcr_terminal_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic       resp_req,
  input logic       cmd_bcast,
  input logic [1:0] acc,
  input logic       err_parity,
  input logic       err_manch,
  input logic       err_sync
);
  AST_CMD_FROM_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> $past(|acc)); // R2
  AST_CMD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> !cmd_valid); // R2
  AST_RESP_NEEDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    resp_req |-> (cmd_valid && !cmd_bcast)); // R3
  AST_UNICAST_RESPONDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_bcast) |-> resp_req); // R3
  AST_BCAST_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_bcast) |-> !resp_req); // R4
  AST_PAR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_parity |=> err_parity); // R5
  AST_MANCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_manch |=> err_manch); // R6
  AST_SYNC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    err_sync |=> err_sync); // R7
  AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(acc)); // R9
endmodule

bind mcr_terminal mcr_terminal_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_valid  (cmd_valid_o),
  .resp_req   (resp_req_o),
  .cmd_bcast  (cmd_bcast_o),
  .acc        (acc_w),
  .err_parity (err_parity_o),
  .err_manch  (err_manch_o),
  .err_sync   (err_sync_o)
);

// File: tb/test_mcr_terminal.sv
module test_mcr_terminal;
  localparam int MAXS = 340;
  localparam int SPB  = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_a = 1'b0, bus_b = 1'b0;
  logic [5:0]  my_addr = 6'd13;
  logic        cmd_valid, resp_req, cmd_bcast, cmd_bus;
  logic [4:0]  cmd_dev;
  logic [3:0]  cmd_type;
  logic [16:0] cmd_data;
  logic        err_parity, err_manch, err_sync;

  logic arr_a [0:MAXS-1];
  logic arr_b [0:MAXS-1];
  int n_checks = 0, n_err = 0;
  int n_cmd = 0, n_resp = 0;

  always #2.5ns clk = ~clk;

  mcr_terminal i_mcr_terminal (
    .clk(clk), .rst_n(rst_n), .bus_a_i(bus_a), .bus_b_i(bus_b),
    .my_addr_i(my_addr), .cmd_valid_o(cmd_valid), .resp_req_o(resp_req),
    .cmd_bcast_o(cmd_bcast), .cmd_bus_o(cmd_bus), .cmd_dev_o(cmd_dev),
    .cmd_type_o(cmd_type), .cmd_data_o(cmd_data), .err_parity_o(err_parity),
    .err_manch_o(err_manch), .err_sync_o(err_sync)
  );

  always @(negedge clk) begin
    if (rst_n && cmd_valid) n_cmd++;
    if (rst_n && resp_req) n_resp++;
  end

  function automatic logic [31:0] mk(int a, int d, int t, int p);
    return {a[5:0], d[4:0], t[3:0], p[16:0]};
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; bus_a = 1'b0; bus_b = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    n_cmd = 0; n_resp = 0;
    for (int k = 0; k < MAXS; k++) begin arr_a[k] = 1'b0; arr_b[k] = 1'b0; end
  endtask

  // manbit: index of the frame bit (0 = first data bit) sent with no transition
  task automatic build(int bus, logic [31:0] w, int ofs, int hi_len, bit badpar, int manbit);
    logic [32:0] v;
    logic b, s2;
    int p;
    v = {w, ~^w ^ badpar};
    p = ofs;
    for (int k = 0; k < hi_len; k++) begin
      if (bus == 0) arr_a[p] = 1'b1; else arr_b[p] = 1'b1;
      p++;
    end
    p = p + 12;
    for (int n = 0; n < 33; n++) begin
      b  = v[32-n];
      s2 = (n == manbit) ? b : ~b;
      for (int k = 0; k < SPB; k++) begin
        if (bus == 0) arr_a[p] = (k < SPB/2) ? b : s2;
        else          arr_b[p] = (k < SPB/2) ? b : s2;
        p++;
      end
    end
  endtask

  task automatic play();
    for (int k = 0; k < MAXS; k++) begin
      @(negedge clk);
      bus_a = arr_a[k];
      bus_b = arr_b[k];
    end
    bus_a = 1'b0; bus_b = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "outputs in reset", {cmd_valid, resp_req, cmd_bcast, cmd_bus,
        cmd_dev, cmd_type, err_parity, err_manch, err_sync}, 0);
    chk("R1", "payload in reset", cmd_data, 0);
    do_reset();
    @(negedge clk);
    chk("R1", "outputs after reset", {cmd_valid, resp_req, err_parity, err_manch, err_sync}, 0);
  endtask

  task automatic t_unicast_a();
    do_reset();
    build(0, mk(13, 7, 3, 'h1A5C3), 2, 12, 0, -1);
    play();
    chk("R2", "cmd count", n_cmd, 1);
    chk("R3", "resp count", n_resp, 1);
    chk("R2", "device", cmd_dev, 7);
    chk("R2", "type", cmd_type, 3);
    chk("R2", "payload", cmd_data, 'h1A5C3);
    chk("R8", "bus A", cmd_bus, 0);
    chk("R2", "no errors", {err_parity, err_manch, err_sync}, 0);
  endtask

  task automatic t_unicast_b();
    do_reset();
    build(1, mk(13, 31, 0, 'h1FFFF), 3, 12, 0, -1);
    play();
    chk("R8", "cmd count bus B", n_cmd, 1);
    chk("R8", "bus B", cmd_bus, 1);
    chk("R2", "device all ones", cmd_dev, 31);
    chk("R2", "payload all ones", cmd_data, 'h1FFFF);
    do_reset();
    build(0, mk(13, 0, 0, 0), 0, 12, 0, -1);
    play();
    chk("R2", "zero word accepted", n_cmd, 1);
    chk("R2", "zero payload", cmd_data, 0);
  endtask

  task automatic t_mismatch();
    do_reset();
    build(0, mk(12, 1, 1, 'h55), 1, 12, 0, -1);
    play();
    chk("R3", "mismatch cmd", n_cmd, 0);
    chk("R3", "mismatch resp", n_resp, 0);
  endtask

  task automatic t_bcast();
    do_reset();
    build(0, mk(63, 2, 15, 'h0ABC), 1, 12, 0, -1);
    play();
    chk("R4", "broadcast cmd", n_cmd, 1);
    chk("R4", "broadcast resp", n_resp, 0);
    chk("R4", "broadcast flag", cmd_bcast, 1);
    chk("R4", "broadcast payload", cmd_data, 'h0ABC);
    do_reset();
    build(0, mk(63, 2, 14, 5), 1, 12, 0, -1);
    play();
    chk("R4", "addr 63 other type ignored", n_cmd, 0);
    do_reset();
    my_addr = 6'd63;
    build(0, mk(63, 2, 14, 5), 1, 12, 0, -1);
    play();
    chk("R4", "addr 63 other type matches strap", n_cmd, 1);
    chk("R3", "addr 63 strap resp", n_resp, 1);
    chk("R4", "not broadcast", cmd_bcast, 0);
    my_addr = 6'd13;
  endtask

  task automatic t_parity();
    do_reset();
    build(0, mk(13, 4, 4, 'h00F0), 1, 12, 1, -1);
    play();
    chk("R5", "bad parity cmd", n_cmd, 0);
    chk("R5", "parity flag", err_parity, 1);
    chk("R5", "no manch flag", err_manch, 0);
    for (int k = 0; k < MAXS; k++) arr_a[k] = 1'b0;
    build(0, mk(13, 4, 4, 'h00F1), 1, 12, 0, -1);
    play();
    chk("R5", "good after bad", n_cmd, 1);
    chk("R5", "parity flag sticky", err_parity, 1);
  endtask

  task automatic t_manch();
    do_reset();
    build(0, mk(13, 9, 2, 'h1234), 1, 12, 0, 10);
    play();
    chk("R6", "manch cmd", n_cmd, 0);
    chk("R6", "manch flag", err_manch, 1);
  endtask

  task automatic t_sync();
    int lens[5] = '{8, 11, 13, 14, 16};
    int good[5] = '{0, 1, 1, 0, 0};
    for (int i = 0; i < 5; i++) begin
      do_reset();
      build(0, mk(13, 3, 3, i), 1, lens[i], 0, -1);
      play();
      chk("R7", $sformatf("cmd, sync high %0d", lens[i]), n_cmd, good[i]);
      if (good[i] == 0) chk("R7", $sformatf("sync flag, high %0d", lens[i]), err_sync, 1);
    end
  endtask

  task automatic t_race();
    do_reset();
    build(0, mk(13, 1, 1, 'h111), 5, 12, 0, -1);
    build(1, mk(13, 2, 2, 'h222), 0, 12, 0, -1);
    play();
    chk("R9", "race one cmd", n_cmd, 1);
    chk("R9", "race bus B wins", cmd_bus, 1);
    chk("R9", "race payload", cmd_data, 'h222);
    do_reset();
    build(0, mk(13, 1, 1, 'h111), 0, 12, 0, -1);
    build(1, mk(13, 2, 2, 'h222), 0, 12, 0, -1);
    play();
    chk("R9", "tie one cmd", n_cmd, 1);
    chk("R9", "tie bus A wins", cmd_bus, 0);
    chk("R9", "tie payload", cmd_data, 'h111);
  endtask

  task automatic t_failover();
    do_reset();
    build(0, mk(13, 1, 1, 'h333), 0, 12, 1, -1);
    build(1, mk(13, 2, 2, 'h444), 4, 12, 0, -1);
    play();
    chk("R10", "failover one cmd", n_cmd, 1);
    chk("R10", "failover bus B", cmd_bus, 1);
    chk("R10", "failover payload", cmd_data, 'h444);
    chk("R10", "leader parity flagged", err_parity, 1);
  endtask

  initial begin
    t_reset();
    t_unicast_a();
    t_unicast_b();
    t_mismatch();
    t_bcast();
    t_parity();
    t_manch();
    t_sync();
    t_race();
    t_failover();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule